// File: doc/BRIEF.md
# Activity Trigger Stability Monitor

This block is a synthesizable checker placed beside a group of enable-gated registers. It observes each register's enable, the value presented at its D input and its current Q output. It also observes two single-bit trigger events, one that announces the group is going quiet (stop) and one that announces it wakes up (start). Its job is to confirm that the group really keeps its state for the whole quiet period. If the group does, a clock-gating enable built from the same two events is safe.

A register counts as stable in a cycle when its enable is low or its D value equals its Q value. All per-register flags are combined into one group flag. A four-state automaton consumes that flag and the two events. The group is watched only after a stop has been followed by a fixed settling delay. Any change seen after that point, and before the next start, latches a violation that only reset clears.

Every pin is a plain level-sampled control or observation signal. No pin carries a data stream, so the block has no valid/ready handshake and never applies back-pressure. The settling delay `DELAY_LEN`, the register count and the register width are elaboration parameters.

Top module: `act_trigger_monitor`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) puts the mode output to 2'b00 (active) and clears the violation output.
- R2: A register is stable in a cycle when its enable bit is 0 or its D slice equals its Q slice. The group flag is true only when every register is stable, and the last register's slice counts like any other.
- R3: In active mode (2'b00), a stop with no start moves the mode to delay (2'b01) at the next edge. The mode stays in delay for DELAY_LEN-1 cycles in total and then becomes idle (2'b10). With DELAY_LEN = 1, it goes from active straight to idle.
- R4: While in delay mode, unstable registers have no effect and never raise a violation.
- R5: A start seen in delay mode returns the mode to active at the next edge, cancelling the countdown.
- R6: In idle mode, a cycle in which the group flag is false and start is low moves the mode to violation (2'b11) at the next edge.
- R7: In idle mode, a start returns the mode to active at the next edge. This holds even when the group flag is false in that same cycle.
- R8: In active mode, stop and start high in the same cycle leave the mode in active, because start takes priority.
- R9: Violation mode is held whatever the inputs until a reset. The violation output is 1 exactly when the mode is 2'b11.
- R10: In active mode, register changes have no effect on the mode or the violation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_en | input | NUM_REGS | Enable of each watched register |
| reg_d | input | NUM_REGS*REG_W | D values, register i in bits [i*REG_W +: REG_W] |
| reg_q | input | NUM_REGS*REG_W | Q values, same packing as reg_d |
| stop_evt | input | 1 | Stop trigger event |
| start_evt | input | 1 | Start trigger event |
| mode | output | 2 | 00 active, 01 delay, 10 idle, 11 violation |
| violation | output | 1 | High while the monitor is in violation mode |

## Verification
Every result of this block is registered once. A mode change or a violation caused by the inputs of one cycle therefore appears on the outputs one rising edge later, and a reset takes effect at the first edge where rst_n is low. The driver sets inputs on the falling edge and queues the outcome due after the following rising edge. The monitor takes each queued item 2 ns after that rising edge and compares it against the outputs, so each check lands exactly one cycle after its stimulus. The delay countdown is checked cycle by cycle in the same way, so an early or late arrival in idle shows as a mismatch.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_DELAY  = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_VIOL   = 2'b11
  } mon_mode_e;

endpackage

// File: rtl/act_reg_stable.sv
module act_reg_stable #(
  parameter int REG_W = 8
) (
  input  logic             en,
  input  logic [REG_W-1:0] d_val,
  input  logic [REG_W-1:0] q_val,
  output logic             stable
);

  // Gated-off register cannot change; an enabled one changes only if D differs from Q.
  always_comb begin
    stable = !en || (d_val == q_val);
  end

endmodule

// File: rtl/act_stab_reduce.sv
module act_stab_reduce #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8
) (
  input  logic [NUM_REGS-1:0]       reg_en,
  input  logic [NUM_REGS*REG_W-1:0] reg_d,
  input  logic [NUM_REGS*REG_W-1:0] reg_q,
  output logic                      all_stable
);

  logic [NUM_REGS-1:0] per_reg;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    act_reg_stable #(.REG_W(REG_W)) u_stab (
      .en     (reg_en[i]),
      .d_val  (reg_d[i*REG_W +: REG_W]),
      .q_val  (reg_q[i*REG_W +: REG_W]),
      .stable (per_reg[i])
    );
  end

  always_comb begin
    all_stable = &per_reg;
  end

endmodule

// File: rtl/act_delay_timer.sv
module act_delay_timer #(
  parameter int DELAY_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic done
);

  localparam int CNT_W = $clog2(DELAY_LEN + 1) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((DELAY_LEN > 1) ? DELAY_LEN - 1 : 1);

  logic [CNT_W-1:0] cnt;

  // Counter rests at 1 outside the delay chain and steps once per delay cycle.
  always_ff @(posedge clk) begin
    if (!rst_n || !advance) begin
      cnt <= CNT_W'(1);
    end else if (cnt != LAST) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    done = (cnt == LAST);
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_W'(1)) && (cnt <= LAST));

endmodule

// File: rtl/act_trigger_monitor.sv
module act_trigger_monitor
  import act_mon_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int REG_W     = 8,
  parameter int DELAY_LEN = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS-1:0]       reg_en,
  input  logic [NUM_REGS*REG_W-1:0] reg_d,
  input  logic [NUM_REGS*REG_W-1:0] reg_q,
  input  logic                      stop_evt,
  input  logic                      start_evt,
  output logic [1:0]                mode,
  output logic                      violation
);

  localparam mon_mode_e AFTER_STOP = (DELAY_LEN > 1) ? MODE_DELAY : MODE_IDLE;

  mon_mode_e state_q, state_d;
  logic      grp_stable;
  logic      delay_done;

  act_stab_reduce #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_reduce (
    .reg_en     (reg_en),
    .reg_d      (reg_d),
    .reg_q      (reg_q),
    .all_stable (grp_stable)
  );

  act_delay_timer #(.DELAY_LEN(DELAY_LEN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (state_q == MODE_DELAY),
    .done    (delay_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_ACTIVE: if (!start_evt && stop_evt) state_d = AFTER_STOP;
      MODE_DELAY: begin
        if (start_evt)       state_d = MODE_ACTIVE;
        else if (delay_done) state_d = MODE_IDLE;
      end
      MODE_IDLE: begin
        if (start_evt)        state_d = MODE_ACTIVE;
        else if (!grp_stable) state_d = MODE_VIOL;
      end
      MODE_VIOL: state_d = MODE_VIOL;
      default:   state_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= MODE_ACTIVE;
    else        state_q <= state_d;
  end

  always_comb begin
    mode      = state_q;
    violation = (state_q == MODE_VIOL);
  end

  // R3
  stop_leaves_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stop_evt && !start_evt) |=> (mode == AFTER_STOP));

  // R8
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && start_evt) |=> (mode == 2'b00));

  // R5
  delay_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && start_evt) |=> (mode == 2'b00));

  // R4
  delay_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> !violation);

  // R6
  idle_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !start_evt && !grp_stable) |=> violation);

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && start_evt) |=> (mode == 2'b00));

  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> (violation && mode == 2'b11));

endmodule

// File: tb/sim_act_trigger_monitor.sv
`timescale 1ns/1ps
module sim_act_trigger_monitor;

  localparam int NR = 4;
  localparam int RW = 8;
  localparam int DL = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     reg_en = '0;
  logic [NR*RW-1:0]  reg_d = '0;
  logic [NR*RW-1:0]  reg_q = '0;
  logic              stop_evt = 1'b0;
  logic              start_evt = 1'b0;
  logic [1:0]        mode;
  logic              violation;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic [1:0] m_state;
  int         m_cnt;

  always #10 clk = ~clk;

  act_trigger_monitor #(.NUM_REGS(NR), .REG_W(RW), .DELAY_LEN(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_d(reg_d), .reg_q(reg_q),
    .stop_evt(stop_evt), .start_evt(start_evt), .mode(mode), .violation(violation)
  );

  function automatic bit grp_ok(logic [NR-1:0] en, logic [NR*RW-1:0] d, logic [NR*RW-1:0] q);
    for (int i = 0; i < NR; i++)
      if (en[i] && d[i*RW +: RW] != q[i*RW +: RW]) return 0;
    return 1;
  endfunction

  // Driver: set inputs on falling edge, queue the mode due after the next rising edge.
  task automatic step(input logic rn, input logic [NR-1:0] en, input logic [NR*RW-1:0] d,
                      input logic [NR*RW-1:0] q, input logic sp, input logic st, input string tag);
    bit ok;
    @(negedge clk);
    rst_n = rn; reg_en = en; reg_d = d; reg_q = q; stop_evt = sp; start_evt = st;
    ok = grp_ok(en, d, q);
    if (!rn) begin
      m_state = 2'b00; m_cnt = 0;
    end else begin
      case (m_state)
        2'b00: if (!st && sp) begin
                 if (DL > 1) begin m_state = 2'b01; m_cnt = 1; end
                 else m_state = 2'b10;
               end
        2'b01: if (st) m_state = 2'b00;
               else if (m_cnt == DL - 1) m_state = 2'b10;
               else m_cnt++;
        2'b10: if (st) m_state = 2'b00;
               else if (!ok) m_state = 2'b11;
        default: m_state = 2'b11;
      endcase
    end
    exp_q.push_back(m_state);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (mode !== e || violation !== (e == 2'b11)) begin
        errors++;
        $display("FAIL %s: mode=%b viol=%b expected mode=%b viol=%b", t, mode, violation, e, e == 2'b11);
      end
    end
  end

  localparam logic [NR*RW-1:0] QV = 32'h4433_2211;
  localparam logic [NR*RW-1:0] DX = 32'h99AA_BBCC;
  localparam logic [NR*RW-1:0] DLAST = 32'h5533_2211;

  initial begin
    m_state = 2'b00; m_cnt = 0;
    step(0, '0, '0, '0, 0, 0, "R1");
    step(0, '0, '0, '0, 0, 0, "R1");
    // R10: active ignores changes
    step(1, '1, DX, QV, 0, 0, "R10");
    step(1, '1, DX, QV, 0, 0, "R10");
    // R8: stop and start together
    step(1, '1, QV, QV, 1, 1, "R8");
    // R3 + R4: stop, changes during delay, countdown to idle
    step(1, '1, QV, QV, 1, 0, "R3");
    step(1, '1, DX, QV, 0, 0, "R4");
    step(1, '1, DX, QV, 0, 0, "R3");
    // R2: idle holds when stable by equality or by disabled enable
    step(1, '1, QV, QV, 0, 0, "R2");
    step(1, '0, DX, QV, 0, 0, "R2");
    step(1, 4'b0001, {DX[31:8], QV[7:0]}, QV, 0, 0, "R2");
    // R7: start from idle
    step(1, '0, QV, QV, 0, 1, "R7");
    // R5: start aborts delay
    step(1, '0, QV, QV, 1, 0, "R3");
    step(1, '0, QV, QV, 0, 1, "R5");
    step(1, '0, QV, QV, 0, 0, "R5");
    // R7: start wins over instability in idle
    step(1, '0, QV, QV, 1, 0, "R3");
    step(1, '0, QV, QV, 0, 0, "R3");
    step(1, '0, QV, QV, 0, 0, "R3");
    step(1, '1, DX, QV, 0, 1, "R7");
    // R6 + R2: last register changes in idle
    step(1, '0, QV, QV, 1, 0, "R3");
    step(1, '0, QV, QV, 0, 0, "R3");
    step(1, '0, QV, QV, 0, 0, "R3");
    step(1, 4'b1000, DLAST, QV, 0, 0, "R6");
    // R9: sticky
    step(1, '0, QV, QV, 0, 1, "R9");
    step(1, '0, QV, QV, 1, 0, "R9");
    step(1, '1, DX, QV, 0, 0, "R9");
    // R1: reset clears violation
    step(0, '0, QV, QV, 0, 0, "R1");
    step(1, '0, QV, QV, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule